// File: doc/BRIEF.md
# Per-lane divided-clock phase calibration sequencer

This block is a control sequencer for one calibration stage of a source-synchronous read-capture path. It sits between an earlier capture-clock stage and a later stage. Once started, it visits the byte lanes one at a time, in ascending order. For each lane it advances the slow, divided clock phase one step at a time. Each step is followed by a settle wait, and then the block samples a pass/fail input. That input reports whether data still crosses correctly from the half-rate capture clock into the divided system clock. The sweep stops at the first failure or at a step-count ceiling. The block then retreats the phase by exactly as many steps as it advanced, so the lane returns to its starting phase.

Each lane is swept twice. The first sweep runs with that lane's inversion select at 0 and the second with it at 1. The number of passing steps in each sweep is the margin for that polarity. The polarity with the larger margin becomes the lane's final select value, and a tie keeps 0. After the last lane, the block raises a one-cycle done pulse. The select outputs then hold until the next start. All pins are plain control and status signals with no streaming data, so no valid/ready handshake is involved.

Top module: `clkdiv_phase_cal`

## Requirements
- R1: A start pulse accepted while idle begins calibration at lane 0. Lanes are processed one at a time in ascending order, and `lane_sel_o` names the lane that every phase step applies to.
- R2: A phase step is a one-cycle high pulse on `phase_step_o`. `phase_dir_o` is 1 for an advance and 0 for a retreat, and the lane's phase is never retreated below its starting value.
- R3: Consecutive phase step pulses are at least SETTLE_CYC+1 cycles apart. After every advance, the pass/fail input is sampled only after SETTLE_CYC+1 settle cycles have elapsed.
- R4: In a sweep, margin is the number of advances after which `xfer_ok_i` was sampled high, counted before the first low sample. The sweep stops after the first failing sample, or after MAX_STEPS passing samples. The advances issued are therefore min(margin+1, MAX_STEPS).
- R5: Each lane's first sweep runs with `inv_sel_o[lane]` = 0 and its second sweep with `inv_sel_o[lane]` = 1. Bit i of `inv_sel_o` belongs to lane i.
- R6: After each sweep, the block issues as many retreat steps as it issued advances. Each lane's net phase is therefore zero when the block moves to the next lane.
- R7: A lane's final `inv_sel_o` bit is 1 only if the margin with select 1 is strictly greater than the margin with select 0. Otherwise the bit is 0.
- R8: `done_o` is high for exactly one cycle after the last lane finishes. The `inv_sel_o` bits then hold until the next accepted start, which clears them all to 0.
- R9: A start pulse while calibration is in progress is ignored. It causes no restart and no second done pulse.
- R10: After reset, `inv_sel_o` is 0 and both `done_o` and `phase_step_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| xfer_ok_i | input | 1 | Pass (1) / fail (0) of the monitored divided-clock transfer |
| phase_step_o | output | 1 | One-cycle phase step command |
| phase_dir_o | output | 1 | Step direction, 1 = advance, 0 = retreat |
| lane_sel_o | output | $clog2(NUM_LANES) | Lane the step and sample apply to |
| inv_sel_o | output | NUM_LANES | Per-lane divided-clock inversion select |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with NUM_LANES=4, MAX_STEPS=6 and SETTLE_CYC=3. A behavioural model of each lane's phase turns the failure point of each polarity into the pass/fail input. Sixteen runs cover every pairing of failure points 0 to 7 for the two polarities. This covers immediate failure, ties, and saturation at the ceiling from both sides, and the model produces the expected select, advance counts and net phase arithmetically. The small settle value and step ceiling keep every run short, so the complete pairing grid fits in a few thousand cycles. One run also pulses start mid-calibration to show that it is ignored.

// File: rtl/clkdiv_cal_pkg.sv
package clkdiv_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADV,
    ST_WAIT_ADV,
    ST_SAMPLE,
    ST_RET,
    ST_WAIT_RET,
    ST_NEXT,
    ST_DONE
  } cal_state_t;
endpackage

// File: rtl/clkdiv_cal_timer.sv
module clkdiv_cal_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = $clog2(SETTLE_CYC + 1) + 1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= TW'(SETTLE_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired_o = (cnt == '0);

  // a new step must never restart a settle window still running (R3)
  p_no_early_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> expired_o);

  // the loaded window always begins counting down (R3)
  p_window_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !expired_o);
endmodule

// File: rtl/clkdiv_cal_sel_bank.sv
module clkdiv_cal_sel_bank #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic [LANE_W-1:0]    wr_lane_i,
  input  logic                 wr_val_i,
  output logic [NUM_LANES-1:0] sel_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        sel_o[g] <= 1'b0;
      end else if (wr_i && (wr_lane_i == LANE_W'(g))) begin
        sel_o[g] <= wr_val_i;
      end
    end
  end

  // a start clears every lane's select (R8)
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sel_o == '0));

  // without a write, the selects hold (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_i) |=> $stable(sel_o));
endmodule

// File: rtl/clkdiv_phase_cal.sv
module clkdiv_phase_cal #(
  parameter int NUM_LANES  = 4,
  parameter int MAX_STEPS  = 6,
  parameter int SETTLE_CYC = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         xfer_ok_i,
  output logic                         phase_step_o,
  output logic                         phase_dir_o,
  output logic [$clog2(NUM_LANES)-1:0] lane_sel_o,
  output logic [NUM_LANES-1:0]         inv_sel_o,
  output logic                         done_o
);
  import clkdiv_cal_pkg::*;

  localparam int LANE_W = $clog2(NUM_LANES);
  localparam int CNT_W  = $clog2(MAX_STEPS + 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);
  localparam logic [CNT_W-1:0]  STEP_CAP  = CNT_W'(MAX_STEPS);

  cal_state_t        state;
  logic [LANE_W-1:0] lane;
  logic              pol;
  logic [CNT_W-1:0]  adv_cnt;
  logic [CNT_W-1:0]  margin;
  logic [CNT_W-1:0]  margin_p0;
  logic              settled;
  logic              sel_clr;
  logic              sel_wr;
  logic              sel_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lane      <= '0;
      pol       <= 1'b0;
      adv_cnt   <= '0;
      margin    <= '0;
      margin_p0 <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          lane    <= '0;
          pol     <= 1'b0;
          adv_cnt <= '0;
          margin  <= '0;
          state   <= ST_ADV;
        end
        ST_ADV: begin
          adv_cnt <= adv_cnt + 1'b1;
          state   <= ST_WAIT_ADV;
        end
        ST_WAIT_ADV: if (settled) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (xfer_ok_i) begin
            margin <= margin + 1'b1;
            state  <= (margin + 1'b1 == STEP_CAP) ? ST_RET : ST_ADV;
          end else begin
            state  <= ST_RET;
          end
        end
        ST_RET: begin
          adv_cnt <= adv_cnt - 1'b1;
          state   <= ST_WAIT_RET;
        end
        ST_WAIT_RET: if (settled) state <= (adv_cnt == '0) ? ST_NEXT : ST_RET;
        ST_NEXT: begin
          margin <= '0;
          if (!pol) begin
            margin_p0 <= margin;
            pol       <= 1'b1;
            state     <= ST_ADV;
          end else begin
            pol <= 1'b0;
            if (lane == LAST_LANE) begin
              state <= ST_DONE;
            end else begin
              lane  <= lane + 1'b1;
              state <= ST_ADV;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_clr = (state == ST_IDLE) && start_i;
  assign sel_wr  = (state == ST_NEXT);
  assign sel_val = !pol || (margin > margin_p0);

  clkdiv_cal_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (phase_step_o),
    .expired_o (settled)
  );

  clkdiv_cal_sel_bank #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (sel_clr),
    .wr_i      (sel_wr),
    .wr_lane_i (lane),
    .wr_val_i  (sel_val),
    .sel_o     (inv_sel_o)
  );

  assign phase_step_o = (state == ST_ADV) || (state == ST_RET);
  assign phase_dir_o  = (state == ST_ADV);
  assign lane_sel_o   = lane;
  assign done_o       = (state == ST_DONE);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_step_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_step_o |=> !phase_step_o);

  p_adv_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_cnt <= STEP_CAP);

  p_restored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT) |-> (adv_cnt == '0));

  p_lane_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_ADV || state == ST_WAIT_RET) |-> $stable(lane_sel_o));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE));
endmodule

// File: tb/clkdiv_phase_cal_tb.sv
module clkdiv_phase_cal_tb;
  localparam int NL = 4;
  localparam int MS = 6;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic xfer_ok_i;
  logic phase_step_o, phase_dir_o, done_o;
  logic [1:0] lane_sel_o;
  logic [NL-1:0] inv_sel_o;

  always #4 clk = ~clk;

  clkdiv_phase_cal #(.NUM_LANES(NL), .MAX_STEPS(MS), .SETTLE_CYC(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xfer_ok_i(xfer_ok_i),
    .phase_step_o(phase_step_o), .phase_dir_o(phase_dir_o),
    .lane_sel_o(lane_sel_o), .inv_sel_o(inv_sel_o), .done_o(done_o));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int phase [NL];
  int minph [NL];
  int adv0 [NL];
  int adv1 [NL];
  int lim0 [NL];
  int lim1 [NL];
  int last_step = -100;
  int gap_bad = 0;
  int order_bad = 0;
  int prev_lane = 0;
  int done_cnt = 0;

  assign xfer_ok_i = inv_sel_o[lane_sel_o] ? (phase[lane_sel_o] <= lim1[lane_sel_o])
                                           : (phase[lane_sel_o] <= lim0[lane_sel_o]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (done_o) done_cnt <= done_cnt + 1;
      if (phase_step_o) begin
        if (cyc - last_step < SC + 1) gap_bad <= gap_bad + 1;
        last_step <= cyc;
        if (int'(lane_sel_o) < prev_lane) order_bad <= order_bad + 1;
        prev_lane <= int'(lane_sel_o);
        if (phase_dir_o) begin
          phase[lane_sel_o] <= phase[lane_sel_o] + 1;
          if (inv_sel_o[lane_sel_o]) adv1[lane_sel_o] <= adv1[lane_sel_o] + 1;
          else                       adv0[lane_sel_o] <= adv0[lane_sel_o] + 1;
        end else begin
          phase[lane_sel_o] <= phase[lane_sel_o] - 1;
          if (phase[lane_sel_o] - 1 < minph[lane_sel_o]) minph[lane_sel_o] <= phase[lane_sel_o] - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int margin_of(input int lim);
    return (lim < MS) ? lim : MS;
  endfunction

  function automatic int exc_of(input int lim);
    return (lim < MS) ? lim + 1 : MS;
  endfunction

  task automatic run(input int r, input bit extra_start);
    int waitc;
    logic [NL-1:0] held;
    for (int l = 0; l < NL; l++) begin
      int idx = r * NL + l;
      lim0[l] = idx % 8;
      lim1[l] = idx / 8;
      phase[l] = 0; minph[l] = 0; adv0[l] = 0; adv1[l] = 0;
    end
    gap_bad = 0; order_bad = 0; prev_lane = 0; done_cnt = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    chk(inv_sel_o == '0, "R8 start clears", int'(inv_sel_o), 0);
    if (extra_start) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    waitc = 0;
    while (done_cnt == 0 && waitc < 5000) begin
      @(negedge clk); waitc++;
    end
    held = inv_sel_o;
    repeat (12) @(negedge clk);
    chk(done_cnt == 1, extra_start ? "R9 single done" : "R8 done pulse", done_cnt, 1);
    chk(inv_sel_o == held, "R8 hold", int'(inv_sel_o), int'(held));
    chk(gap_bad == 0, "R3 settle gap", gap_bad, 0);
    chk(order_bad == 0, "R1 lane order", order_bad, 0);
    for (int l = 0; l < NL; l++) begin
      int m0 = margin_of(lim0[l]);
      int m1 = margin_of(lim1[l]);
      chk(inv_sel_o[l] == (m1 > m0), "R7 select", int'(inv_sel_o[l]), int'(m1 > m0));
      chk(phase[l] == 0, "R6 restore", phase[l], 0);
      chk(minph[l] == 0, "R2 no underrun", minph[l], 0);
      chk(adv0[l] == exc_of(lim0[l]), "R4 advances pol0", adv0[l], exc_of(lim0[l]));
      chk(adv1[l] == exc_of(lim1[l]), "R5 advances pol1", adv1[l], exc_of(lim1[l]));
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      phase[l] = 0; lim0[l] = 0; lim1[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(inv_sel_o == '0, "R10 reset sel", int'(inv_sel_o), 0);
    chk(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
    chk(phase_step_o == 1'b0, "R10 reset step", int'(phase_step_o), 0);
    for (int r = 0; r < 16; r++) run(r, r == 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule